// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is a half-duplex serial port that shifts one byte at a time over two wires. One wire is a shift clock that the block always drives. The other wire is a single data line that the block drives to transmit and releases to receive. A small write port takes either a control word or a data byte. The control word holds the mode bits, a receive-enable bit and two completion flags. The last received byte and the control word are always visible on output ports.

Software writes a byte into the data slot to send it. The byte leaves least-significant bit first, one bit per shift-clock cycle. To receive, software writes a control word that selects shift mode, sets receive-enable and clears the receive flag. The port then pulses the clock eight times and assembles the incoming bits least-significant first. An 8-bit reload input sets how many system clocks each half of a shift-clock cycle lasts. The divider that uses it runs only while a byte is moving.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk_o` is 1, `sdat_o` is 1, `sdat_oe` is 1, `ctrl_q` is 0x00 and `rx_byte` is 0x00.
- R2: A data write (`wr_sel`=1) while idle with control bits [7:6] both 0 starts a transmission. Bit k of the byte is on `sdat_o`, with `sdat_oe`=1, from the start of shift cycle k to its end, for k=0..7.
- R3: Each shift cycle is a high phase of `sclk_o` followed by a low phase. Each phase lasts `div_reload`+1 system clocks, counted from the write that started the transfer.
- R4: At the end of the eighth shift cycle of a transmission, `sdat_o` returns to 1, `sclk_o` stays at 1 and the transmit-done flag (control bit 1) is set.
- R5: A control write (`wr_sel`=0) while idle starts a reception when the written value has bits [7:6]=00, bit 4 (receive-enable)=1 and bit 0 (receive-done)=0. `sdat_oe` is 0 for the whole reception.
- R6: During reception, `sdat_i` is sampled at each rising edge of `sclk_o`, the first sample going to bit 0. After the eighth sample, `rx_byte` holds the byte and control bit 0 is set.
- R7: A control write stores all eight bits as written. The two done flags, once set by hardware, stay set until a control write clears them.
- R8: A data write while a transfer is running is ignored: the running transfer keeps its byte and its timing.
- R9: While control bits [7:6] are not both 0, a data write starts no transfer. A control write whose value has bits [7:6] not both 0 starts no reception.
- R10: A control write with bit 4 clear, or with bit 0 set, starts no reception.
- R11: While no transfer is running, `sclk_o` is held at 1 and does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the data slot |
| wr_data | input | 8 | Value written |
| div_reload | input | DIV_W | Half-period length minus one, in system clocks |
| ctrl_q | output | 8 | Current control word, including the done flags |
| rx_byte | output | 8 | Last byte received |
| sclk_o | output | 1 | Shift clock, idles high |
| sdat_o | output | 1 | Data line output value |
| sdat_oe | output | 1 | Data line output enable, 0 during reception |
| sdat_i | input | 1 | Data line input value |

## Verification
The in-RTL assertions check several invariants on every cycle. The clock stays high when idle, and the data line is released during reception. Transmit data holds still through each low phase. The divider counts down by one per clock. The done flags persist without a control write, and a non-shift mode keeps the engine idle. Other behaviour is not a per-cycle invariant and shows only in the bench scenarios: the exact bit order on the wire, the byte assembled from sampled bits, and the phase lengths under different reload values. The same holds for the rejection of writes during a transfer and of incomplete receive commands. These scenarios are compared against a timing model that counts clocks from the start write.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 8;
  localparam int BIT_M1  = 7;
  localparam int BIT_M0  = 6;
  localparam int BIT_REN = 4;
  localparam int BIT_TXD = 1;
  localparam int BIT_RXD = 0;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;
endpackage

// File: rtl/ssp_div.sv
module ssp_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= reload;
    end else if (cnt == '0) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && ($past(cnt) != '0)) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              busy,
  input  logic              fin,
  input  logic              fin_rx,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              start_tx,
  output logic              start_rx
);
  logic              ctrl_wr;
  logic              data_wr;
  logic [CTRL_W-1:0] ctrl_nxt;

  assign ctrl_wr = wr_en && !wr_sel;
  assign data_wr = wr_en && wr_sel;

  assign start_tx = data_wr && !busy && !ctrl_q[BIT_M1] && !ctrl_q[BIT_M0];
  assign start_rx = ctrl_wr && !busy && !wr_data[BIT_M1] && !wr_data[BIT_M0]
                    && wr_data[BIT_REN] && !wr_data[BIT_RXD];

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (ctrl_wr) ctrl_nxt = wr_data;
    if (fin) begin
      if (fin_rx) ctrl_nxt[BIT_RXD] = 1'b1;
      else        ctrl_nxt[BIT_TXD] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nxt;
  end

  // R7
  tx_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && ctrl_q[BIT_TXD]) |=> ctrl_q[BIT_TXD]);
  // R7
  rx_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && ctrl_q[BIT_RXD]) |=> ctrl_q[BIT_RXD]);
  // R4
  tx_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && !fin_rx) |=> ctrl_q[BIT_TXD]);
  // R9
  mode_block_chk: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q[BIT_M1] || ctrl_q[BIT_M0]) && !busy && !ctrl_wr) |=> !busy);
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_tx,
  input  logic              start_rx,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              sdat_i,
  output logic              busy,
  output logic              fin,
  output logic              fin_rx,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              sdat_oe,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

  logic              busy_q;
  dir_e              dir_q;
  logic              low_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              sclk_q;
  logic              sdo_q;
  logic              oe_q;
  logic [DATA_W-1:0] rxw_q;
  logic              edge_rise;

  assign edge_rise = busy_q && tick && low_q;
  assign fin       = edge_rise && (bit_q == LAST);
  assign fin_rx    = (dir_q == DIR_RX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_TX;
      low_q  <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b1;
      sdo_q  <= 1'b1;
      oe_q   <= 1'b1;
      rxw_q  <= '0;
    end else if (!busy_q) begin
      if (start_tx) begin
        busy_q <= 1'b1;
        dir_q  <= DIR_TX;
        low_q  <= 1'b0;
        bit_q  <= '0;
        sh_q   <= tx_byte;
        sdo_q  <= tx_byte[0];
        oe_q   <= 1'b1;
        sclk_q <= 1'b1;
      end else if (start_rx) begin
        busy_q <= 1'b1;
        dir_q  <= DIR_RX;
        low_q  <= 1'b0;
        bit_q  <= '0;
        sh_q   <= '0;
        oe_q   <= 1'b0;
        sclk_q <= 1'b1;
      end
    end else if (tick) begin
      if (!low_q) begin
        low_q  <= 1'b1;
        sclk_q <= 1'b0;
      end else begin
        low_q  <= 1'b0;
        sclk_q <= 1'b1;
        if (dir_q == DIR_RX) sh_q <= {sdat_i, sh_q[DATA_W-1:1]};
        else                 sh_q <= {1'b1, sh_q[DATA_W-1:1]};
        if (bit_q == LAST) begin
          busy_q <= 1'b0;
          sdo_q  <= 1'b1;
          oe_q   <= 1'b1;
          if (dir_q == DIR_RX) rxw_q <= {sdat_i, sh_q[DATA_W-1:1]};
        end else begin
          bit_q <= bit_q + 1'b1;
          if (dir_q == DIR_TX) sdo_q <= sh_q[1];
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sclk_o  = sclk_q;
  assign sdat_o  = sdo_q;
  assign sdat_oe = oe_q;
  assign rx_byte = rxw_q;

  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> sclk_q);
  // R5
  rx_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dir_q == DIR_RX) |-> !oe_q);
  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && !sclk_q) |-> $stable(sdo_q));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  div_reload,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              sdat_oe,
  input  logic              sdat_i
);
  logic busy, fin, fin_rx, start_tx, start_rx, tick;

  ssp_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .busy     (busy),
    .fin      (fin),
    .fin_rx   (fin_rx),
    .ctrl_q   (ctrl_q),
    .start_tx (start_tx),
    .start_rx (start_rx)
  );

  ssp_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .reload (div_reload),
    .tick   (tick)
  );

  ssp_engine u_eng (
    .clk      (clk),
    .rst      (rst),
    .start_tx (start_tx),
    .start_rx (start_rx),
    .tx_byte  (wr_data[DATA_W-1:0]),
    .tick     (tick),
    .sdat_i   (sdat_i),
    .busy     (busy),
    .fin      (fin),
    .fin_rx   (fin_rx),
    .sclk_o   (sclk_o),
    .sdat_o   (sdat_o),
    .sdat_oe  (sdat_oe),
    .rx_byte  (rx_byte)
  );
endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] div_reload = 8'h00;
  logic [7:0] ctrl_q;
  logic [7:0] rx_byte;
  logic       sclk_o, sdat_o, sdat_oe;
  logic       sdat_i = 1'b1;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_shift_port u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .div_reload(div_reload), .ctrl_q(ctrl_q), .rx_byte(rx_byte),
    .sclk_o(sclk_o), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i)
  );

  // timing model: cycles counted from the start write
  bit       m_busy = 0;
  bit       m_rx = 0;
  int       m_t = 0;
  int       m_L = 1;
  bit [7:0] m_byte = 0;
  bit [7:0] m_ctrl = 0;
  bit [7:0] m_rxbyte = 0;
  bit [7:0] m_rxsh = 0;

  always @(posedge clk) begin
    bit fin;
    fin = 0;
    if (rst) begin
      m_busy = 0; m_ctrl = 0; m_rxbyte = 0; m_t = 0;
    end else begin
      if (m_busy) begin
        m_t = m_t + 1;
        if (m_rx && (m_t % (2 * m_L) == 0)) m_rxsh[m_t / (2 * m_L) - 1] = sdat_i;
        if (m_t == 16 * m_L) begin m_busy = 0; fin = 1; end
      end else if (wr_en) begin
        if (wr_sel && m_ctrl[7:6] == 2'b00) begin
          m_busy = 1; m_rx = 0; m_t = 0; m_L = int'(div_reload) + 1; m_byte = wr_data;
        end else if (!wr_sel && wr_data[7:6] == 2'b00 && wr_data[4] && !wr_data[0]) begin
          m_busy = 1; m_rx = 1; m_t = 0; m_L = int'(div_reload) + 1; m_rxsh = 0;
        end
      end
      if (wr_en && !wr_sel) m_ctrl = wr_data;
      if (fin) begin
        if (m_rx) begin m_ctrl[0] = 1; m_rxbyte = m_rxsh; end
        else m_ctrl[1] = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit e_sclk, e_oe, e_sdo;
    if (!rst) begin
      e_sclk = !m_busy || ((m_t / m_L) % 2 == 0);
      e_oe   = !(m_busy && m_rx);
      e_sdo  = (m_busy && !m_rx) ? m_byte[m_t / (2 * m_L)] : 1'b1;
      chk(sclk_o === e_sclk, "R3 sclk", int'(sclk_o), int'(e_sclk));
      chk(sdat_oe === e_oe, "R5 oe", int'(sdat_oe), int'(e_oe));
      if (e_oe) chk(sdat_o === e_sdo, "R2 sdat", int'(sdat_o), int'(e_sdo));
      chk(ctrl_q === m_ctrl, "R7 ctrl", int'(ctrl_q), int'(m_ctrl));
      chk(rx_byte === m_rxbyte, "R6 rx_byte", int'(rx_byte), int'(m_rxbyte));
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  task automatic rx_drive(input logic [7:0] b, input int L);
    for (int k = 0; k < 8; k++) begin
      sdat_i = b[k];
      repeat (2 * L) @(negedge clk);
    end
    sdat_i = 1'b1;
  endtask

  task automatic idle_watch(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(sclk_o === 1'b1 && sdat_oe === 1'b1, req, int'({sclk_o, sdat_oe}), 3);
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(sclk_o === 1 && sdat_o === 1 && sdat_oe === 1, "R1 pins", int'({sclk_o, sdat_o, sdat_oe}), 7);
    chk(ctrl_q === 8'h00 && rx_byte === 8'h00, "R1 regs", int'({ctrl_q, rx_byte}), 0);

    // R10: rx_en clear, nothing starts
    wr(0, 8'h00);
    idle_watch(6, "R10 no start");
    // R2 transmit, reload 0
    wr(1, 8'hA5);
    chk(sdat_o === 1'b1 && sclk_o === 1'b1, "R2 first bit", int'({sdat_o, sclk_o}), 3);
    wait_idle();
    // R4
    chk(ctrl_q[1] === 1'b1 && sdat_o === 1'b1 && sclk_o === 1'b1, "R4 done", int'({ctrl_q[1], sdat_o, sclk_o}), 7);
    // R7 flag persists, then cleared
    repeat (10) @(negedge clk);
    chk(ctrl_q[1] === 1'b1, "R7 hold", int'(ctrl_q[1]), 1);
    wr(0, 8'h00);
    chk(ctrl_q === 8'h00, "R7 clear", int'(ctrl_q), 0);

    // R8: write during transfer ignored, reload 2
    div_reload = 8'd2;
    wr(1, 8'h3C);
    repeat (7) @(negedge clk);
    wr(1, 8'hFF);
    chk(m_busy && sdat_o === m_byte[m_t / (2 * m_L)] && m_byte == 8'h3C, "R8 kept byte",
        int'(sdat_o), int'(m_byte[m_t / (2 * m_L)]));
    wait_idle();
    chk(ctrl_q === 8'h02, "R8 single done", int'(ctrl_q), 2);

    // R5 R6 receive, reload 1
    div_reload = 8'd1;
    wr(0, 8'h10);
    chk(sdat_oe === 1'b0, "R5 released", int'(sdat_oe), 0);
    rx_drive(8'h96, 2);
    wait_idle();
    chk(rx_byte === 8'h96, "R6 byte", int'(rx_byte), 8'h96);
    chk(ctrl_q === 8'h11, "R6 flag", int'(ctrl_q), 8'h11);

    // R10: rx_done set in written value
    wr(0, 8'h11);
    idle_watch(8, "R10 flag set");
    // R9: non-shift modes
    wr(0, 8'h40);
    wr(1, 8'h55);
    idle_watch(6, "R9 tx blocked");
    wr(0, 8'hD0);
    idle_watch(6, "R9 rx blocked");
    chk(ctrl_q === 8'hD0, "R9 ctrl", int'(ctrl_q), 8'hD0);
    // R11: long idle
    idle_watch(20, "R11 idle");

    // R6 receive, reload 3
    div_reload = 8'd3;
    wr(0, 8'h10);
    rx_drive(8'h6B, 4);
    wait_idle();
    chk(rx_byte === 8'h6B, "R6 byte2", int'(rx_byte), 8'h6B);

    // R2 R4 transmit MSB only, reload 1
    div_reload = 8'd1;
    wr(1, 8'h80);
    wait_idle();
    chk(ctrl_q === 8'h13, "R7 both flags", int'(ctrl_q), 8'h13);
    chk(rx_byte === 8'h6B, "R2 tx leaves rx_byte", int'(rx_byte), 8'h6B);
    repeat (4) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule